// File: doc/BRIEF.md
# Square-Wave and Interrupt Output Controller

This block holds an 8-bit control register and the logic that turns it into output pin behaviour for a timekeeping device. It runs from a timebase clock at twice the 32.768 kHz reference rate (65.536 kHz), so one clock cycle is half a reference period. Bit 0 of an internal counter reproduces the reference waveform, and the remaining 15 bits form the divider that produces the lower square-wave rates. A stop bit holds the divider cleared and forces its output low. The same bit drives an oscillator-run enable output.

Two active-low pins carry the alarm requests. The dedicated pin serves alarm 1. The shared pin carries either the selected square wave or the alarm 2 interrupt, depending on the interrupt-control bit. When that bit is 0, alarm 2 is folded onto the dedicated pin so that it is still reported. The alarm flags arrive as inputs. The alarm enables are bits in the control register.

Register layout (bit: meaning): 7 oscillator stop (1 = stopped), 6:5 reserved, 4:3 rate code, 2 interrupt control, 1 alarm 2 enable, 0 alarm 1 enable.

Top module: `sqw_int_ctrl`

## Requirements
- R1: After reset the register reads 8'h18 (running, rate code 11, interrupt control 0, both enables 0), osc_en_o is 1 and int_a_no is 1.
- R2: A write with wr_en_i high is captured at that clock edge, and rd_data_o returns bits 7 and 4:0 of the written value from then on.
- R3: Bits 6:5 ignore writes and always read 0; writing 8'hFF reads back 8'h9F.
- R4: osc_en_o is the inverse of register bit 7.
- R5: With bit 2 at 0 and rate code 2'b11, the shared pin toggles every cycle (32.768 kHz, half period of 1 cycle).
- R6: Rate code 2'b10 gives a half period of 4 cycles (8.192 kHz), 2'b01 gives 8 cycles (4.096 kHz) and 2'b00 gives 32768 cycles (1 Hz).
- R7: While bit 7 is 1 the divider is held cleared and, with bit 2 at 0, the shared pin stays low.
- R8: With bit 2 at 1, int_a_no is low exactly when a1_flag_i and bit 0 are both 1. Its state is due one edge after the inputs.
- R9: With bit 2 at 1, int_b_no is low exactly when a2_flag_i and bit 1 are both 1. Its state is due one edge after the inputs.
- R10: With bit 2 at 0, int_a_no is low when either enabled alarm is flagged, and int_b_no carries the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock, twice the 32.768 kHz reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| a1_flag_i | input | 1 | Alarm 1 match flag |
| a2_flag_i | input | 1 | Alarm 2 match flag |
| rd_data_o | output | 8 | Register read data |
| osc_en_o | output | 1 | Oscillator run enable |
| int_a_no | output | 1 | Dedicated alarm 1 pin, active low |
| int_b_no | output | 1 | Shared square-wave / alarm 2 pin |

## Verification
The register and osc_en_o change at the same edge that captures a write. The interrupt pins follow their flags and enables one edge later. The square wave passes through three registers, namely the counter, the tap register and the pin register, so it reaches the shared pin up to three edges after a rate or stop change. The bench therefore samples snapshots three falling edges after it drives a stimulus. It measures half periods only after it has discarded two transitions, so the run that straddles a rate change is never judged.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       osc_off;
    logic [1:0] rsv;
    logic [1:0] rate;
    logic       intcn;
    logic       a2_ie;
    logic       a1_ie;
  } ctrl_t;

  typedef enum logic [1:0] {
    RATE_1HZ = 2'b00,
    RATE_4K  = 2'b01,
    RATE_8K  = 2'b10,
    RATE_32K = 2'b11
  } rate_e;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h18;
  localparam logic [CTRL_W-1:0] RW_MASK  = 8'h9F;
endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i & RW_MASK);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/sqw_rate_div.sv
module sqw_rate_div
  import sqw_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       wave_o
);
  localparam int CNT_W    = DIV_W + 1;
  localparam int TAP_32K  = 0;
  localparam int TAP_8K   = 2;
  localparam int TAP_4K   = 3;
  localparam int TAP_1HZ  = DIV_W;
  localparam int TAP_W    = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W-1:0] tap;
  logic             wave_q;

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_1HZ: tap = TAP_W'(TAP_1HZ);
      RATE_4K:  tap = TAP_W'(TAP_4K);
      RATE_8K:  tap = TAP_W'(TAP_8K);
      default:  tap = TAP_W'(TAP_32K);
    endcase
  end

  // bit 0 is the reference itself; bits above form the divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // registered tap: a rate switch lands on an edge, never a sub-cycle pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= run_i & cnt_q[tap];
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/sqw_pin_mux.sv
module sqw_pin_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intcn_i,
  input  logic a1_ie_i,
  input  logic a2_ie_i,
  input  logic a1_flag_i,
  input  logic a2_flag_i,
  input  logic wave_i,
  output logic int_a_no,
  output logic int_b_no
);
  logic a1_req, a2_req, a_act, b_lvl;
  logic a_q, b_q;

  assign a1_req = a1_flag_i & a1_ie_i;
  assign a2_req = a2_flag_i & a2_ie_i;
  // alarm 2 falls back to the dedicated pin while the shared pin carries the wave
  assign a_act  = intcn_i ? a1_req : (a1_req | a2_req);
  assign b_lvl  = intcn_i ? ~a2_req : wave_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b1;
      b_q <= 1'b0;
    end else begin
      a_q <= ~a_act;
      b_q <= b_lvl;
    end
  end

  assign int_a_no = a_q;
  assign int_b_no = b_q;
endmodule

// File: rtl/sqw_int_ctrl.sv
module sqw_int_ctrl
  import sqw_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              a1_flag_i,
  input  logic              a2_flag_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              osc_en_o,
  output logic              int_a_no,
  output logic              int_b_no
);
  ctrl_t ctrl;
  logic  wave;

  sqw_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  sqw_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (~ctrl.osc_off),
    .rate_i (ctrl.rate),
    .wave_o (wave)
  );

  sqw_pin_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .intcn_i   (ctrl.intcn),
    .a1_ie_i   (ctrl.a1_ie),
    .a2_ie_i   (ctrl.a2_ie),
    .a1_flag_i (a1_flag_i),
    .a2_flag_i (a2_flag_i),
    .wave_i    (wave),
    .int_a_no  (int_a_no),
    .int_b_no  (int_b_no)
  );

  assign rd_data_o = ctrl;
  assign osc_en_o  = ~ctrl.osc_off;
endmodule

// File: rtl/sqw_int_ctrl_chk.sv
module sqw_int_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       a1_flag_i,
  input logic       a2_flag_i,
  input logic [7:0] rd_data_o,
  input logic       osc_en_o,
  input logic       int_a_no,
  input logic       int_b_no
);
  // R2 R3
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {$past(wr_data_i[7]), 2'b00, $past(wr_data_i[4:0])});

  // R4
  osc_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o == !rd_data_o[7]);

  // R8
  int_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2] |=> int_a_no == !($past(a1_flag_i) && $past(rd_data_o[0])));

  // R9
  int_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2] |=> int_b_no == !($past(a2_flag_i) && $past(rd_data_o[1])));

  // R7
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] && $past(rd_data_o[7]) && !rd_data_o[2]) |=> !int_b_no);

  // R10
  fold_a2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[2] && a2_flag_i && rd_data_o[1]) |=> !int_a_no);
endmodule

bind sqw_int_ctrl sqw_int_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .a1_flag_i (a1_flag_i),
  .a2_flag_i (a2_flag_i),
  .rd_data_o (rd_data_o),
  .osc_en_o  (osc_en_o),
  .int_a_no  (int_a_no),
  .int_b_no  (int_b_no)
);

// File: tb/sqw_int_ctrl_bench.sv
module sqw_int_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       a1_flag = 1'b0;
  logic       a2_flag = 1'b0;
  logic [7:0] rd_data;
  logic       osc_en, int_a_n, int_b_n;

  int checks = 0;
  int errors = 0;
  bit busy = 0;
  bit done = 0;

  // kind 0: snapshot, 1: half-period of int_b_n, 2: int_b_n held low
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] num;
    logic        exp_a;
    logic        exp_b;
    logic        chk_b;
    logic [7:0]  exp_rd;
    logic        exp_osc;
  } item_t;

  item_t exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  sqw_int_ctrl u_sqw_int_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .a1_flag_i (a1_flag),
    .a2_flag_i (a2_flag),
    .rd_data_o (rd_data),
    .osc_en_o  (osc_en),
    .int_a_no  (int_a_n),
    .int_b_no  (int_b_n)
  );

  task automatic push(item_t it, string req);
    exp_q.push_back(it);
    req_q.push_back(req);
    @(negedge clk);
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic snap(logic a, logic b, logic cb, logic [7:0] r, logic o, string req);
    item_t it;
    it = '{kind: 2'd0, num: 32'd3, exp_a: a, exp_b: b, chk_b: cb, exp_rd: r, exp_osc: o};
    push(it, req);
  endtask

  task automatic half(int len, string req);
    item_t it;
    it = '{kind: 2'd1, num: len, exp_a: 1'b1, exp_b: 1'b0, chk_b: 1'b0, exp_rd: 8'h0, exp_osc: 1'b1};
    push(it, req);
  endtask

  task automatic hold_low(int len, string req);
    item_t it;
    it = '{kind: 2'd2, num: len, exp_a: 1'b1, exp_b: 1'b0, chk_b: 1'b1, exp_rd: 8'h0, exp_osc: 1'b0};
    push(it, req);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flags(logic f1, logic f2);
    @(negedge clk);
    a1_flag = f1;
    a2_flag = f2;
  endtask

  task automatic fail(string req, int act, int expv);
    errors++;
    $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
  endtask

  // monitor: pops expectations and compares at falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        item_t it;
        string req;
        busy = 1;
        it = exp_q.pop_front();
        req = req_q.pop_front();
        checks++;
        if (it.kind == 2'd0) begin
          repeat (int'(it.num)) @(negedge clk);
          if (rd_data !== it.exp_rd) fail(req, rd_data, it.exp_rd);
          else if (osc_en !== it.exp_osc) fail(req, osc_en, it.exp_osc);
          else if (int_a_n !== it.exp_a) fail(req, int_a_n, it.exp_a);
          else if (it.chk_b && int_b_n !== it.exp_b) fail(req, int_b_n, it.exp_b);
        end else if (it.kind == 2'd1) begin
          logic prev;
          int run;
          // discard two transitions so the run across a rate change is not judged
          for (int k = 0; k < 2; k++) begin
            prev = int_b_n;
            run = 0;
            while (int_b_n == prev && run < 40000) begin
              @(negedge clk);
              run++;
            end
          end
          prev = int_b_n;
          run = 0;
          while (int_b_n == prev && run < 40000) begin
            @(negedge clk);
            run++;
          end
          if (run != int'(it.num)) fail(req, run, it.num);
        end else begin
          int bad = 0;
          repeat (int'(it.num)) begin
            @(negedge clk);
            if (int_b_n !== 1'b0 || osc_en !== 1'b0) bad++;
          end
          if (bad != 0) fail(req, bad, 0);
        end
        busy = 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    snap(1'b1, 1'b0, 1'b0, 8'h18, 1'b1, "R1");
    // R5 32.768 kHz
    half(1, "R5");
    // R2 rate 10
    wr(8'h10);
    snap(1'b1, 1'b0, 1'b0, 8'h10, 1'b1, "R2");
    // R6 8.192 kHz then 4.096 kHz
    half(4, "R6");
    wr(8'h08);
    half(8, "R6");
    // R3 R4 reserved bits and stop bit; intcn=1, no flags
    wr(8'hFF);
    snap(1'b1, 1'b1, 1'b1, 8'h9F, 1'b0, "R3");
    // R7 stopped, intcn=0
    wr(8'h98);
    hold_low(40, "R7");
    // R8 R9 intcn=1, both enables, running, 1 Hz code
    wr(8'h07);
    flags(1'b1, 1'b0);
    snap(1'b0, 1'b1, 1'b1, 8'h07, 1'b1, "R8");
    flags(1'b0, 1'b1);
    snap(1'b1, 1'b0, 1'b1, 8'h07, 1'b1, "R9");
    wr(8'h06);
    flags(1'b1, 1'b0);
    snap(1'b1, 1'b1, 1'b1, 8'h06, 1'b1, "R8");
    wr(8'h05);
    flags(1'b0, 1'b1);
    snap(1'b1, 1'b1, 1'b1, 8'h05, 1'b1, "R9");
    // R10 intcn=0: alarm 2 on dedicated pin, wave on shared pin
    wr(8'h1B);
    snap(1'b0, 1'b0, 1'b0, 8'h1B, 1'b1, "R10");
    half(1, "R10");
    flags(1'b0, 1'b0);
    snap(1'b1, 1'b0, 1'b0, 8'h1B, 1'b1, "R10");
    // R6 1 Hz
    wr(8'h00);
    half(32768, "R6");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule